// File: doc/BRIEF.md
# Leaf Interrupt Status Bank

This block collects three hardware error events of one module into a small bank of software-visible registers. The events are a CRC failure, a bad length and an uncorrectable ECC failure. Each event sets a status bit that stays set until software clears it by writing a one. Two mask registers pick which status bits drive the interrupt summary line and which drive the halt summary line. By default the two recoverable errors raise an interrupt and only the ECC failure raises a halt.

When the ECC failure is reported, the block also records the 4-bit ID of the bus master that was active at that moment. The ID sits in the upper nibble of the status word. It is captured only when the field is empty, so it keeps the first offender until software clears it. The field is informational only and never reaches the summary lines.

Software reaches the bank through a plain word port: an address, write data, a write strobe and registered read data. The summary lines are registered and feed an upper aggregation level.

Top module: `irq_leaf_bank`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active-high reset), the bank clears all status bits and the master ID to 0, loads the interrupt mask with 3'b011 and the halt mask with 3'b100, and drives `irq`, `halt` and `rd_data` low.
- R2: A high level on an event input at a clock edge sets its status bit: CRC at bit 0, length at bit 1, ECC at bit 2 of the word at offset 0x0. Bit 3 reads 0.
- R3: A write to offset 0x0 clears each status bit whose write-data bit is 1. A write-data bit of 0 leaves its status bit unchanged.
- R4: If an event and a software clear hit the same status bit in the same cycle, the bit ends set.
- R5: The master ID field at bits 7:4 of offset 0x0 loads `ecc_master` on an ECC event only when the field, after any clear in that cycle, is zero. Otherwise a later ECC event leaves it unchanged.
- R6: A write of ones to bits 7:4 at offset 0x0 clears the matching master ID bits. A nonzero ID with all status bits clear drives neither `irq` nor `halt`.
- R7: The interrupt mask sits at offset 0x4 and the halt mask at offset 0x8, in bits 2:0 with the same bit order as the status. Both can be read and written.
- R8: `irq` equals the OR of (status AND interrupt mask) as it stood one clock edge earlier, so it rises one cycle after the status bit.
- R9: `halt` equals the OR of (status AND halt mask) as it stood one clock edge earlier.
- R10: `rd_data` shows, one edge after `addr` is applied, the register at that offset. Offsets other than 0x0, 0x4 and 0x8 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_crc | input | 1 | CRC failure event |
| evt_len | input | 1 | Bad length event |
| evt_ecc | input | 1 | Uncorrectable ECC event |
| ecc_master | input | ID_W | Active master ID, sampled with `evt_ecc` |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt summary |
| halt | output | 1 | Registered halt summary |

## Verification
The bench builds the block with its default parameters: three events, a 4-bit master ID at bit 4, a 4-bit address and a 32-bit data word. At that size all 512 combinations of status pattern, interrupt mask and halt mask can be swept. For each one the bench checks both summary lines, the one-cycle lag of the summary lines and the status readback, and the sweep walks every one of the 16 master ID values. Directed sequences then cover set-versus-clear collisions, partial clears of the ID, the first-offender hold and the unmapped offsets.

// File: rtl/irq_leaf_pkg.sv
package irq_leaf_pkg;
  localparam int unsigned EVT_N   = 3;
  localparam int unsigned EVT_CRC = 0;
  localparam int unsigned EVT_LEN = 1;
  localparam int unsigned EVT_ECC = 2;

  localparam int unsigned OFS_STAT = 'h0;
  localparam int unsigned OFS_IMSK = 'h4;
  localparam int unsigned OFS_HMSK = 'h8;
endpackage

// File: rtl/irq_leaf_status.sv
module irq_leaf_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         stat[i] <= 1'b0;
      else if (evt[i]) stat[i] <= 1'b1;
      else if (clr[i]) stat[i] <= 1'b0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> stat[i]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !evt[i]) |=> !stat[i]);
    assert_quiet_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && !evt[i]) |=> $stable(stat[i]));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && evt[i]) |=> stat[i]);
  end
endmodule

// File: rtl/irq_leaf_master_id.sv
module irq_leaf_master_id #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_evt,
  input  logic [ID_W-1:0] id_in,
  input  logic [ID_W-1:0] clr,
  output logic [ID_W-1:0] id_q
);
  logic [ID_W-1:0] id_kept;
  assign id_kept = id_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst)                                id_q <= '0;
    else if (load_evt && (id_kept == '0))   id_q <= id_in;
    else                                    id_q <= id_kept;
  end

  assert_first_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (id_q != '0 && clr == '0) |=> $stable(id_q));
  assert_empty_loads_R5: assert property (@(posedge clk) disable iff (rst)
    (id_q == '0 && load_evt) |=> id_q == $past(id_in));
  assert_clear_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (!load_evt) |=> ((id_q & $past(clr)) == '0));
endmodule

// File: rtl/irq_leaf_mask.sv
module irq_leaf_mask #(
  parameter int unsigned N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= wdata;
  end

  assert_mask_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
  assert_mask_loads_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> q == $past(wdata));
endmodule

// File: rtl/irq_leaf_summary.sv
module irq_leaf_summary #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] imsk,
  input  logic [N-1:0] hmsk,
  output logic         irq,
  output logic         halt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      halt <= 1'b0;
    end else begin
      irq  <= |(stat & imsk);
      halt <= |(stat & hmsk);
    end
  end
endmodule

// File: rtl/irq_leaf_bank.sv
module irq_leaf_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ID_LSB = 4,
  parameter logic [2:0]  IMSK_RST = 3'b011,
  parameter logic [2:0]  HMSK_RST = 3'b100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_crc,
  input  logic              evt_len,
  input  logic              evt_ecc,
  input  logic [ID_W-1:0]   ecc_master,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              halt
);
  import irq_leaf_pkg::*;
  localparam int unsigned N = EVT_N;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(OFS_IMSK);
  localparam logic [ADDR_W-1:0] A_HMSK = ADDR_W'(OFS_HMSK);

  logic           hit_stat, hit_imsk, hit_hmsk;
  logic [N-1:0]   evt_vec, stat_clr, stat, imsk, hmsk;
  logic [ID_W-1:0] id_clr, id_q;
  logic [DATA_W-1:0] rd_next;
  logic           unused_wbits;

  assign hit_stat = (addr == A_STAT);
  assign hit_imsk = (addr == A_IMSK);
  assign hit_hmsk = (addr == A_HMSK);

  always_comb begin
    evt_vec = '0;
    evt_vec[EVT_CRC] = evt_crc;
    evt_vec[EVT_LEN] = evt_len;
    evt_vec[EVT_ECC] = evt_ecc;
  end

  assign stat_clr = (wr_en && hit_stat) ? wr_data[N-1:0] : '0;
  assign id_clr   = (wr_en && hit_stat) ? wr_data[ID_LSB +: ID_W] : '0;
  assign unused_wbits = ^wr_data;

  irq_leaf_status #(.N(N)) u_status (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(stat_clr), .stat(stat)
  );

  irq_leaf_master_id #(.ID_W(ID_W)) u_mid (
    .clk(clk), .rst(rst), .load_evt(evt_ecc), .id_in(ecc_master),
    .clr(id_clr), .id_q(id_q)
  );

  irq_leaf_mask #(.N(N), .RST_VAL(IMSK_RST)) u_imsk (
    .clk(clk), .rst(rst), .we(wr_en && hit_imsk), .wdata(wr_data[N-1:0]), .q(imsk)
  );

  irq_leaf_mask #(.N(N), .RST_VAL(HMSK_RST)) u_hmsk (
    .clk(clk), .rst(rst), .we(wr_en && hit_hmsk), .wdata(wr_data[N-1:0]), .q(hmsk)
  );

  irq_leaf_summary #(.N(N)) u_sum (
    .clk(clk), .rst(rst), .stat(stat), .imsk(imsk), .hmsk(hmsk),
    .irq(irq), .halt(halt)
  );

  always_comb begin
    rd_next = '0;
    if (hit_stat) begin
      rd_next[N-1:0]          = stat;
      rd_next[ID_LSB +: ID_W] = id_q;
    end else if (hit_imsk) begin
      rd_next[N-1:0] = imsk;
    end else if (hit_hmsk) begin
      rd_next[N-1:0] = hmsk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(stat & imsk)));
  assert_halt_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> halt == $past(|(stat & hmsk)));
  assert_id_no_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (stat == '0) |=> (!irq && !halt));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!hit_stat && !hit_imsk && !hit_hmsk) |=> rd_data == '0);
endmodule

// File: tb/irq_leaf_bank_bench.sv
`timescale 1ns/1ps
module irq_leaf_bank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_crc = 0, evt_len = 0, evt_ecc = 0;
  logic [3:0]  ecc_master = '0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 0;
  logic [31:0] rd_data;
  logic        irq, halt;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_leaf_bank u_irq_leaf_bank (
    .clk(clk), .rst(rst), .evt_crc(evt_crc), .evt_len(evt_len), .evt_ecc(evt_ecc),
    .ecc_master(ecc_master), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .irq(irq), .halt(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic pulse(input logic [2:0] p, input logic [3:0] m);
    @(negedge clk); {evt_ecc, evt_len, evt_crc} = p; ecc_master = m;
    @(negedge clk); {evt_ecc, evt_len, evt_crc} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 halt", {31'b0, halt}, 0);
    rd(4'h0, v); chk("R1 status", v, 0);
    rd(4'h4, v); chk("R1 imask", v, 32'h3);
    rd(4'h8, v); chk("R1 hmask", v, 32'h4);
    // R8/R9 default masks: ECC halts only
    pulse(3'b100, 4'h0);
    @(negedge clk);
    chk("R9 ecc halt", {31'b0, halt}, 1);
    chk("R8 ecc no irq", {31'b0, irq}, 0);
    pulse(3'b001, 4'h0);
    @(negedge clk);
    chk("R8 crc irq", {31'b0, irq}, 1);
    // R3 write 0 no effect, write 1 clears
    do_reset();
    pulse(3'b011, 4'h0);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R3 w0 no effect", v, 32'h3);
    wr(4'h0, 32'h2);
    rd(4'h0, v); chk("R2 R3 clear len only", v, 32'h1);
    // R4 collision: set wins
    @(negedge clk); addr = 4'h0; wr_data = 32'h1; wr_en = 1; evt_crc = 1;
    @(negedge clk); wr_en = 0; evt_crc = 0; wr_data = '0;
    rd(4'h0, v); chk("R4 set wins", v, 32'h1);
    @(negedge clk); addr = 4'h0; wr_data = 32'h1; wr_en = 1; evt_len = 1;
    @(negedge clk); wr_en = 0; evt_len = 0; wr_data = '0;
    rd(4'h0, v); chk("R4 other bit clears", v, 32'h2);
    // R5 R6 master id
    wr(4'h0, 32'hFF);
    pulse(3'b100, 4'h5);
    rd(4'h0, v); chk("R5 id load", v, 32'h54);
    wr(4'h0, 32'h4);
    rd(4'h0, v); chk("R5 id held after status clear", v, 32'h50);
    pulse(3'b100, 4'h9);
    rd(4'h0, v); chk("R5 first id kept", v, 32'h54);
    wr(4'h8, 32'h7);
    wr(4'h4, 32'h7);
    wr(4'h0, 32'h7);
    repeat (2) @(negedge clk);
    chk("R6 id no irq", {31'b0, irq}, 0);
    chk("R6 id no halt", {31'b0, halt}, 0);
    wr(4'h0, 32'h30);
    rd(4'h0, v); chk("R6 partial id clear", v, 32'h40);
    wr(4'h0, 32'hF0);
    rd(4'h0, v); chk("R6 full id clear", v, 32'h0);
    pulse(3'b100, 4'hA);
    rd(4'h0, v); chk("R5 reload after clear", v, 32'hA4);
    // R7 mask readback
    wr(4'h4, 32'h5);
    rd(4'h4, v); chk("R7 imask rw", v, 32'h5);
    wr(4'h8, 32'h2);
    rd(4'h8, v); chk("R7 hmask rw", v, 32'h2);
    // R10 unmapped
    rd(4'hC, v); chk("R10 read C", v, 0);
    rd(4'h2, v); chk("R10 read 2", v, 0);
    wr(4'h6, 32'hFF);
    wr(4'h1, 32'hFF);
    rd(4'h4, v); chk("R10 write ignored imask", v, 32'h5);
    rd(4'h8, v); chk("R10 write ignored hmask", v, 32'h2);
    rd(4'h0, v); chk("R10 write ignored status", v, 32'hA4);
    // sweep: every status pattern x imask x hmask
    do_reset();
    for (int s = 0; s < 8; s++)
      for (int im = 0; im < 8; im++)
        for (int hm = 0; hm < 8; hm++) begin
          logic [3:0] m;
          logic [31:0] exp_st;
          m = 4'((im * 8 + hm) % 16);
          wr(4'h4, 32'(im));
          wr(4'h8, 32'(hm));
          pulse(3'(s), m);
          chk("R8 registered lag", {31'b0, irq}, 0);
          @(negedge clk);
          chk("R8 sweep irq", {31'b0, irq}, {31'b0, ((s & im) != 0)});
          chk("R9 sweep halt", {31'b0, halt}, {31'b0, ((s & hm) != 0)});
          exp_st = 32'(s) | ((s & 4) != 0 ? (32'(m) << 4) : 32'h0);
          rd(4'h0, v); chk("R2 sweep status", v, exp_st);
          wr(4'h0, 32'hF7);
          @(negedge clk);
        end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule